// File: doc/BRIEF.md
# Call Gate Privilege Checker

This block decides the outcome of a far control transfer that goes through a gate descriptor, and of the matching far return. The descriptor fetch has already happened. The caller presents these values in a single cycle:

- the current privilege level;
- the requested privilege of the selector it used;
- the fields of the gate;
- the kind, privilege and presence of the descriptor that the gate points at.

One clock later the block answers with one of two outcomes. The first is a fault code plus the selector that caused the fault. The second is a transfer decision: the new code selector, the new instruction offset, the new privilege level, whether a stack switch is needed, and how many parameter words must be copied.

Two checks are kept apart. The privilege of the gate controls who may use it. The privilege of the destination code segment controls the level the callee runs at. The offset the caller supplied is discarded, because the entry point comes from the gate. Chained gates are refused, and so are calls that would move outward. Returns are checked against the requested privilege bits of the saved code selector. Stack copying itself is left to the surrounding logic.

Top module: `gate_priv_check`

## Requirements
- R1: After reset, `rsp_valid`, `fault`, `stack_switch`, `new_cs`, `new_ip`, `new_cpl` and `copy_words` are all zero.
- R2: For a call, the effective level is the numerically larger of `cur_pl` and `sel_rpl`. If that level is numerically greater than `gate_dpl`, the call faults with code 13 and `fault_sel` equals `call_sel`.
- R3: For a call whose destination privilege `dest_dpl` is numerically greater than `cur_pl` (an outward call), the call faults with code 13 and `fault_sel` equals `gate_dest_sel`.
- R4: For a successful call, `new_ip` equals `gate_dest_off`, and `call_off` has no effect on it.
- R5: For a call whose destination kind is not code (`dest_kind` encoding: 0 code, 1 data, 2 gate, 3 system), the call faults with code 13 and `fault_sel` equals `gate_dest_sel`. This covers gate chaining (kind 2).
- R6: A successful inward call (`dest_dpl` < `cur_pl`) sets the following outputs:
  - `stack_switch` = 1;
  - `copy_words` = `gate_wc`;
  - `new_cpl` = `dest_dpl`;
  - `new_cs` = `gate_dest_sel` with its low two bits replaced by `dest_dpl`.
- R7: A successful same-level call (`dest_dpl` = `cur_pl`) gives `stack_switch` = 0 and `copy_words` = 0, whatever the value of `gate_wc`.
- R8: A jump (`req_op` = 1) or a data access (`req_op` = 2) through a gate faults with code 13 and `fault_sel` equals `call_sel`. `req_op` = 0 is a call and `req_op` = 3 is a return.
- R9: A not-present descriptor gives fault code 11. This is checked only after the gate privilege passes.
  - A clear `gate_present` reports `call_sel`.
  - A clear `dest_present` reports `gate_dest_sel`.
- R10: A return compares `ret_sel[1:0]` with `cur_pl`.
  - If it is greater, the return is outward: `stack_switch` = 1.
  - If it is equal, the return stays at the same level: `stack_switch` = 0.
  - In both of these cases `new_cs` = `ret_sel`, `new_ip` = `ret_off`, `new_cpl` = `ret_sel[1:0]` and `copy_words` = 0.
  - If it is lower, the return faults with code 13 and `fault_sel` = `ret_sel`.
- R11: A faulting request leaves `new_cs`, `new_ip`, `new_cpl`, `stack_switch` and `copy_words` at their previous values.
- R12: `rsp_valid` is high exactly one cycle after a cycle with `req_valid` high, and is low otherwise.
- R13: A call through a gate whose `gate_type` is not the call-gate code (4'hC) faults with code 13 and `fault_sel` equals `call_sel`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_op | input | 2 | 0 call, 1 jump, 2 data access, 3 return |
| cur_pl | input | 2 | Current privilege level |
| sel_rpl | input | 2 | Requested privilege of the caller's selector |
| call_sel | input | 16 | Selector the caller used (reported on gate faults) |
| call_off | input | 16 | Offset the caller supplied (discarded) |
| gate_present | input | 1 | Gate present bit |
| gate_dpl | input | 2 | Gate privilege level |
| gate_type | input | 4 | Gate type code, 4'hC is a call gate |
| gate_dest_sel | input | 16 | Destination selector held in the gate |
| gate_dest_off | input | 16 | Destination offset held in the gate |
| gate_wc | input | 5 | Parameter word count held in the gate |
| dest_kind | input | 2 | Kind of the destination descriptor |
| dest_present | input | 1 | Destination descriptor present bit |
| dest_dpl | input | 2 | Destination code segment privilege |
| ret_sel | input | 16 | Saved code selector for a return |
| ret_off | input | 16 | Saved instruction offset for a return |
| rsp_valid | output | 1 | Decision valid |
| fault | output | 1 | Request faulted |
| fault_code | output | 8 | 13 protection, 11 not present |
| fault_sel | output | 16 | Offending selector |
| new_cs | output | 16 | New code selector |
| new_ip | output | 16 | New instruction offset |
| new_cpl | output | 2 | New current privilege level |
| stack_switch | output | 1 | Stack switch needed |
| copy_words | output | 5 | Parameter words to copy |

## Verification
The bench targets the points where the privilege comparisons sit next to each other. These are:

- a selector's requested privilege that is weaker than the current level but still allowed by the current level alone;
- an outward destination behind a gate that is otherwise usable;
- a destination that is itself a gate;
- a return whose saved privilege is stronger than the current one.

A design that compared only the current level would accept the weak selector. A design that merged the gate check with the destination check would let outward calls through. A design that resolved chains would jump through a second gate.

The bench also checks that a same-level call with a non-zero word count copies nothing. It checks that the caller's offset never reaches `new_ip`. It checks that a fault leaves the last transfer outputs unchanged, which a design that updated them anyway would break.

// File: rtl/cgpc_pkg.sv
package cgpc_pkg;
   typedef enum logic [1:0] {
      OP_CALL = 2'd0,
      OP_JUMP = 2'd1,
      OP_DATA = 2'd2,
      OP_RET  = 2'd3
   } gate_op_e;

   typedef enum logic [1:0] {
      DK_CODE = 2'd0,
      DK_DATA = 2'd1,
      DK_GATE = 2'd2,
      DK_SYS  = 2'd3
   } dest_kind_e;
endpackage

// File: rtl/cgpc_call_eval.sv
module cgpc_call_eval
   import cgpc_pkg::*;
#(
   parameter int SEL_W     = 16,
   parameter int OFF_W     = 16,
   parameter int PL_W      = 2,
   parameter int WC_W      = 5,
   parameter int TYPE_W    = 4,
   parameter int FC_W      = 8,
   parameter int GATE_TYPE = 12,
   parameter int GP_CODE   = 13,
   parameter int NP_CODE   = 11,
   parameter bit USE_RPL   = 1'b1
) (
   input  logic [1:0]        op,
   input  logic [PL_W-1:0]   cpl,
   input  logic [PL_W-1:0]   rpl,
   input  logic [SEL_W-1:0]  csel,
   input  logic              g_present,
   input  logic [PL_W-1:0]   g_dpl,
   input  logic [TYPE_W-1:0] g_type,
   input  logic [SEL_W-1:0]  g_sel,
   input  logic [OFF_W-1:0]  g_off,
   input  logic [WC_W-1:0]   g_wc,
   input  logic [1:0]        d_kind,
   input  logic              d_present,
   input  logic [PL_W-1:0]   d_dpl,
   output logic              flt,
   output logic [FC_W-1:0]   flt_code,
   output logic [SEL_W-1:0]  flt_sel,
   output logic [SEL_W-1:0]  tgt_cs,
   output logic [OFF_W-1:0]  tgt_ip,
   output logic [PL_W-1:0]   tgt_pl,
   output logic              tgt_sw,
   output logic [WC_W-1:0]   tgt_cnt
);
   localparam logic [FC_W-1:0]   GP = FC_W'(GP_CODE);
   localparam logic [FC_W-1:0]   NP = FC_W'(NP_CODE);
   localparam logic [TYPE_W-1:0] CG = TYPE_W'(GATE_TYPE);

   logic [PL_W-1:0] eff_pl;
   logic            inward;

   generate
      if (USE_RPL) begin : g_rpl_merge
         assign eff_pl = (rpl > cpl) ? rpl : cpl;
      end else begin : g_cpl_only
         assign eff_pl = cpl;
      end
   endgenerate

   assign inward  = d_dpl < cpl;
   assign tgt_cs  = {g_sel[SEL_W-1:PL_W], d_dpl};
   assign tgt_ip  = g_off;
   assign tgt_pl  = d_dpl;
   assign tgt_sw  = inward;
   assign tgt_cnt = inward ? g_wc : '0;

   always_comb begin
      flt      = 1'b0;
      flt_code = '0;
      flt_sel  = '0;
      if (gate_op_e'(op) != OP_CALL) begin
         flt = 1'b1; flt_code = GP; flt_sel = csel;
      end else if (g_type != CG) begin
         flt = 1'b1; flt_code = GP; flt_sel = csel;
      end else if (eff_pl > g_dpl) begin
         flt = 1'b1; flt_code = GP; flt_sel = csel;
      end else if (!g_present) begin
         flt = 1'b1; flt_code = NP; flt_sel = csel;
      end else if (dest_kind_e'(d_kind) != DK_CODE) begin
         flt = 1'b1; flt_code = GP; flt_sel = g_sel;
      end else if (d_dpl > cpl) begin
         flt = 1'b1; flt_code = GP; flt_sel = g_sel;
      end else if (!d_present) begin
         flt = 1'b1; flt_code = NP; flt_sel = g_sel;
      end
   end
endmodule

// File: rtl/cgpc_ret_eval.sv
module cgpc_ret_eval #(
   parameter int SEL_W   = 16,
   parameter int OFF_W   = 16,
   parameter int PL_W    = 2,
   parameter int FC_W    = 8,
   parameter int GP_CODE = 13
) (
   input  logic [PL_W-1:0]  cpl,
   input  logic [SEL_W-1:0] rsel,
   input  logic [OFF_W-1:0] roff,
   output logic             flt,
   output logic [FC_W-1:0]  flt_code,
   output logic [SEL_W-1:0] flt_sel,
   output logic [SEL_W-1:0] tgt_cs,
   output logic [OFF_W-1:0] tgt_ip,
   output logic [PL_W-1:0]  tgt_pl,
   output logic             tgt_sw
);
   logic [PL_W-1:0] saved_pl;

   assign saved_pl = rsel[PL_W-1:0];
   assign flt      = saved_pl < cpl;
   assign flt_code = flt ? FC_W'(GP_CODE) : '0;
   assign flt_sel  = rsel;
   assign tgt_cs   = rsel;
   assign tgt_ip   = roff;
   assign tgt_pl   = saved_pl;
   assign tgt_sw   = saved_pl > cpl;
endmodule

// File: rtl/cgpc_result_reg.sv
module cgpc_result_reg #(
   parameter int SEL_W = 16,
   parameter int OFF_W = 16,
   parameter int PL_W  = 2,
   parameter int WC_W  = 5,
   parameter int FC_W  = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   input  logic             in_flt,
   input  logic [FC_W-1:0]  in_code,
   input  logic [SEL_W-1:0] in_fsel,
   input  logic [SEL_W-1:0] in_cs,
   input  logic [OFF_W-1:0] in_ip,
   input  logic [PL_W-1:0]  in_pl,
   input  logic             in_sw,
   input  logic [WC_W-1:0]  in_cnt,
   output logic             o_valid,
   output logic             o_flt,
   output logic [FC_W-1:0]  o_code,
   output logic [SEL_W-1:0] o_fsel,
   output logic [SEL_W-1:0] o_cs,
   output logic [OFF_W-1:0] o_ip,
   output logic [PL_W-1:0]  o_pl,
   output logic             o_sw,
   output logic [WC_W-1:0]  o_cnt
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         o_valid <= 1'b0;
         o_flt   <= 1'b0;
         o_code  <= '0;
         o_fsel  <= '0;
         o_cs    <= '0;
         o_ip    <= '0;
         o_pl    <= '0;
         o_sw    <= 1'b0;
         o_cnt   <= '0;
      end else begin
         o_valid <= in_valid;
         if (in_valid) begin
            o_flt <= in_flt;
            if (in_flt) begin
               o_code <= in_code;
               o_fsel <= in_fsel;
            end else begin
               o_code <= '0;
               o_fsel <= '0;
               o_cs   <= in_cs;
               o_ip   <= in_ip;
               o_pl   <= in_pl;
               o_sw   <= in_sw;
               o_cnt  <= in_cnt;
            end
         end
      end
   end
endmodule

// File: rtl/gate_priv_check.sv
module gate_priv_check #(
   parameter int SEL_W     = 16,
   parameter int OFF_W     = 16,
   parameter int PL_W      = 2,
   parameter int WC_W      = 5,
   parameter int TYPE_W    = 4,
   parameter int FC_W      = 8,
   parameter int GATE_TYPE = 12,
   parameter int GP_CODE   = 13,
   parameter int NP_CODE   = 11,
   parameter bit USE_RPL   = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [1:0]        req_op,
   input  logic [PL_W-1:0]   cur_pl,
   input  logic [PL_W-1:0]   sel_rpl,
   input  logic [SEL_W-1:0]  call_sel,
   input  logic [OFF_W-1:0]  call_off,
   input  logic              gate_present,
   input  logic [PL_W-1:0]   gate_dpl,
   input  logic [TYPE_W-1:0] gate_type,
   input  logic [SEL_W-1:0]  gate_dest_sel,
   input  logic [OFF_W-1:0]  gate_dest_off,
   input  logic [WC_W-1:0]   gate_wc,
   input  logic [1:0]        dest_kind,
   input  logic              dest_present,
   input  logic [PL_W-1:0]   dest_dpl,
   input  logic [SEL_W-1:0]  ret_sel,
   input  logic [OFF_W-1:0]  ret_off,
   output logic              rsp_valid,
   output logic              fault,
   output logic [FC_W-1:0]   fault_code,
   output logic [SEL_W-1:0]  fault_sel,
   output logic [SEL_W-1:0]  new_cs,
   output logic [OFF_W-1:0]  new_ip,
   output logic [PL_W-1:0]   new_cpl,
   output logic              stack_switch,
   output logic [WC_W-1:0]   copy_words
);
   import cgpc_pkg::*;

   localparam int MAX_CODE = (1 << FC_W) - 1;

   generate
      if (SEL_W <= PL_W + 1) begin : g_bad_sel
         $error("selector too narrow for privilege and table bits");
      end
      if (GP_CODE > MAX_CODE || NP_CODE > MAX_CODE) begin : g_bad_code
         $error("fault code does not fit");
      end
      if (GATE_TYPE >= (1 << TYPE_W)) begin : g_bad_type
         $error("gate type does not fit");
      end
   endgenerate

   logic             c_flt, r_flt, is_ret;
   logic [FC_W-1:0]  c_code, r_code;
   logic [SEL_W-1:0] c_fsel, r_fsel, c_cs, r_cs;
   logic [OFF_W-1:0] c_ip, r_ip;
   logic [PL_W-1:0]  c_pl, r_pl;
   logic             c_sw, r_sw;
   logic [WC_W-1:0]  c_cnt;

   logic             m_flt, m_sw;
   logic [FC_W-1:0]  m_code;
   logic [SEL_W-1:0] m_fsel, m_cs;
   logic [OFF_W-1:0] m_ip;
   logic [PL_W-1:0]  m_pl;
   logic [WC_W-1:0]  m_cnt;

   logic             unused_off;
   assign unused_off = ^call_off;

   cgpc_call_eval #(
      .SEL_W(SEL_W), .OFF_W(OFF_W), .PL_W(PL_W), .WC_W(WC_W),
      .TYPE_W(TYPE_W), .FC_W(FC_W), .GATE_TYPE(GATE_TYPE),
      .GP_CODE(GP_CODE), .NP_CODE(NP_CODE), .USE_RPL(USE_RPL)
   ) u_call (
      .op(req_op), .cpl(cur_pl), .rpl(sel_rpl), .csel(call_sel),
      .g_present(gate_present), .g_dpl(gate_dpl), .g_type(gate_type),
      .g_sel(gate_dest_sel), .g_off(gate_dest_off), .g_wc(gate_wc),
      .d_kind(dest_kind), .d_present(dest_present), .d_dpl(dest_dpl),
      .flt(c_flt), .flt_code(c_code), .flt_sel(c_fsel),
      .tgt_cs(c_cs), .tgt_ip(c_ip), .tgt_pl(c_pl),
      .tgt_sw(c_sw), .tgt_cnt(c_cnt)
   );

   cgpc_ret_eval #(
      .SEL_W(SEL_W), .OFF_W(OFF_W), .PL_W(PL_W), .FC_W(FC_W),
      .GP_CODE(GP_CODE)
   ) u_ret (
      .cpl(cur_pl), .rsel(ret_sel), .roff(ret_off),
      .flt(r_flt), .flt_code(r_code), .flt_sel(r_fsel),
      .tgt_cs(r_cs), .tgt_ip(r_ip), .tgt_pl(r_pl), .tgt_sw(r_sw)
   );

   assign is_ret = gate_op_e'(req_op) == OP_RET;

   always_comb begin
      if (is_ret) begin
         m_flt = r_flt; m_code = r_code; m_fsel = r_fsel;
         m_cs  = r_cs;  m_ip   = r_ip;   m_pl   = r_pl;
         m_sw  = r_sw;  m_cnt  = '0;
      end else begin
         m_flt = c_flt; m_code = c_code; m_fsel = c_fsel;
         m_cs  = c_cs;  m_ip   = c_ip;   m_pl   = c_pl;
         m_sw  = c_sw;  m_cnt  = c_cnt;
      end
   end

   cgpc_result_reg #(
      .SEL_W(SEL_W), .OFF_W(OFF_W), .PL_W(PL_W), .WC_W(WC_W), .FC_W(FC_W)
   ) u_out (
      .clk(clk), .rst_n(rst_n), .in_valid(req_valid),
      .in_flt(m_flt), .in_code(m_code), .in_fsel(m_fsel),
      .in_cs(m_cs), .in_ip(m_ip), .in_pl(m_pl), .in_sw(m_sw), .in_cnt(m_cnt),
      .o_valid(rsp_valid), .o_flt(fault), .o_code(fault_code),
      .o_fsel(fault_sel), .o_cs(new_cs), .o_ip(new_ip), .o_pl(new_cpl),
      .o_sw(stack_switch), .o_cnt(copy_words)
   );
endmodule

// File: rtl/cgpc_checker.sv
module cgpc_checker #(
   parameter int SEL_W   = 16,
   parameter int OFF_W   = 16,
   parameter int PL_W    = 2,
   parameter int WC_W    = 5,
   parameter int FC_W    = 8,
   parameter int GP_CODE = 13,
   parameter int NP_CODE = 11
) (
   input logic             clk,
   input logic             rst_n,
   input logic             req_valid,
   input logic [1:0]       req_op,
   input logic [PL_W-1:0]  cur_pl,
   input logic [OFF_W-1:0] gate_dest_off,
   input logic             rsp_valid,
   input logic             fault,
   input logic [FC_W-1:0]  fault_code,
   input logic [SEL_W-1:0] new_cs,
   input logic [OFF_W-1:0] new_ip,
   input logic [PL_W-1:0]  new_cpl,
   input logic             stack_switch,
   input logic [WC_W-1:0]  copy_words
);
   p_valid_follows_req_r12: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> $past(req_valid));

   p_fault_code_legal_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && fault) |-> (fault_code == FC_W'(GP_CODE) || fault_code == FC_W'(NP_CODE)));

   p_fault_holds_state_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && fault) |-> ($stable(new_cs) && $stable(new_ip) && $stable(new_cpl)));

   p_no_outward_call_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && !fault && $past(req_op) == 2'd0) |-> (new_cpl <= $past(cur_pl)));

   p_gate_offset_used_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && !fault && $past(req_op) == 2'd0) |-> (new_ip == $past(gate_dest_off)));

   p_copy_needs_switch_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && !fault && copy_words != '0) |-> stack_switch);

   p_cpl_in_selector_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && !fault) |-> (new_cs[PL_W-1:0] == new_cpl));
endmodule

bind gate_priv_check cgpc_checker #(
   .SEL_W(SEL_W), .OFF_W(OFF_W), .PL_W(PL_W), .WC_W(WC_W), .FC_W(FC_W),
   .GP_CODE(GP_CODE), .NP_CODE(NP_CODE)
) u_chk (
   .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
   .cur_pl(cur_pl), .gate_dest_off(gate_dest_off), .rsp_valid(rsp_valid),
   .fault(fault), .fault_code(fault_code), .new_cs(new_cs), .new_ip(new_ip),
   .new_cpl(new_cpl), .stack_switch(stack_switch), .copy_words(copy_words)
);

// File: tb/sim_gate_priv_check.sv
module sim_gate_priv_check;
   localparam time CLK_PERIOD = 10ns;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [1:0]  req_op = 2'd0;
   logic [1:0]  cur_pl = 2'd3;
   logic [1:0]  sel_rpl = 2'd3;
   logic [15:0] call_sel = 16'h0043;
   logic [15:0] call_off = 16'hBEEF;
   logic        gate_present = 1'b1;
   logic [1:0]  gate_dpl = 2'd3;
   logic [3:0]  gate_type = 4'hC;
   logic [15:0] gate_dest_sel = 16'h0028;
   logic [15:0] gate_dest_off = 16'h1234;
   logic [4:0]  gate_wc = 5'd5;
   logic [1:0]  dest_kind = 2'd0;
   logic        dest_present = 1'b1;
   logic [1:0]  dest_dpl = 2'd0;
   logic [15:0] ret_sel = 16'h0000;
   logic [15:0] ret_off = 16'h0000;
   logic        rsp_valid, fault, stack_switch;
   logic [7:0]  fault_code;
   logic [15:0] fault_sel, new_cs, new_ip;
   logic [1:0]  new_cpl;
   logic [4:0]  copy_words;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   gate_priv_check u0 (.*);

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic defaults();
      req_op = 2'd0; cur_pl = 2'd3; sel_rpl = 2'd3; call_sel = 16'h0043;
      call_off = 16'hBEEF; gate_present = 1'b1; gate_dpl = 2'd3;
      gate_type = 4'hC; gate_dest_sel = 16'h0028; gate_dest_off = 16'h1234;
      gate_wc = 5'd5; dest_kind = 2'd0; dest_present = 1'b1; dest_dpl = 2'd0;
   endtask

   task automatic fire();
      req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   task automatic expect_fault(input string req, input logic [7:0] code, input logic [15:0] sel);
      chk({req, " valid"}, 32'(rsp_valid), 32'd1);
      chk({req, " fault"}, 32'(fault), 32'd1);
      chk({req, " code"}, 32'(fault_code), 32'(code));
      chk({req, " sel"}, 32'(fault_sel), 32'(sel));
   endtask

   task automatic t_reset_r1();
      chk("R1 valid", 32'(rsp_valid), 32'd0);
      chk("R1 fault", 32'(fault), 32'd0);
      chk("R1 cs", 32'(new_cs), 32'd0);
      chk("R1 ip", 32'(new_ip), 32'd0);
      chk("R1 cpl", 32'(new_cpl), 32'd0);
      chk("R1 sw", 32'(stack_switch), 32'd0);
      chk("R1 cnt", 32'(copy_words), 32'd0);
   endtask

   task automatic t_inward_r6();
      defaults();
      fire();
      chk("R6 fault", 32'(fault), 32'd0);
      chk("R6 cs", 32'(new_cs), 32'h0028);
      chk("R4 ip", 32'(new_ip), 32'h1234);
      chk("R6 cpl", 32'(new_cpl), 32'd0);
      chk("R6 sw", 32'(stack_switch), 32'd1);
      chk("R6 cnt", 32'(copy_words), 32'd5);
      chk("R12 valid high", 32'(rsp_valid), 32'd1);
      @(negedge clk);
      chk("R12 valid low", 32'(rsp_valid), 32'd0);
   endtask

   task automatic t_inward_lvl1_r6();
      defaults();
      dest_dpl = 2'd1; gate_dest_sel = 16'h0038; gate_wc = 5'd31;
      fire();
      chk("R6 cs lvl1", 32'(new_cs), 32'h0039);
      chk("R6 cpl lvl1", 32'(new_cpl), 32'd1);
      chk("R6 cnt max", 32'(copy_words), 32'd31);
   endtask

   task automatic t_same_r7();
      defaults();
      cur_pl = 2'd0; sel_rpl = 2'd0; gate_dpl = 2'd0; dest_dpl = 2'd0;
      gate_dest_sel = 16'h0030; gate_dest_off = 16'h5678; gate_wc = 5'd7;
      call_off = 16'h5679;
      fire();
      chk("R7 fault", 32'(fault), 32'd0);
      chk("R7 sw", 32'(stack_switch), 32'd0);
      chk("R7 cnt", 32'(copy_words), 32'd0);
      chk("R4 ip ignores caller", 32'(new_ip), 32'h5678);
      chk("R7 cs", 32'(new_cs), 32'h0030);
   endtask

   task automatic t_gate_priv_r2();
      defaults();
      gate_dpl = 2'd0;
      fire();
      expect_fault("R2 cpl", 8'd13, 16'h0043);
      chk("R11 cs held", 32'(new_cs), 32'h0030);
      chk("R11 ip held", 32'(new_ip), 32'h5678);
      defaults();
      cur_pl = 2'd0; sel_rpl = 2'd3; gate_dpl = 2'd2; call_sel = 16'h0047;
      fire();
      expect_fault("R2 rpl", 8'd13, 16'h0047);
      chk("R11 cpl held", 32'(new_cpl), 32'd0);
      chk("R11 sw held", 32'(stack_switch), 32'd0);
   endtask

   task automatic t_outward_r3();
      defaults();
      cur_pl = 2'd0; sel_rpl = 2'd0; dest_dpl = 2'd3;
      fire();
      expect_fault("R3", 8'd13, 16'h0028);
   endtask

   task automatic t_chain_r5();
      defaults();
      dest_kind = 2'd2; gate_dest_sel = 16'h0050;
      fire();
      expect_fault("R5 gate", 8'd13, 16'h0050);
      defaults();
      dest_kind = 2'd1;
      fire();
      expect_fault("R5 data", 8'd13, 16'h0028);
   endtask

   task automatic t_jump_r8();
      defaults();
      req_op = 2'd1;
      fire();
      expect_fault("R8 jump", 8'd13, 16'h0043);
      defaults();
      req_op = 2'd2;
      fire();
      expect_fault("R8 data", 8'd13, 16'h0043);
   endtask

   task automatic t_present_r9();
      defaults();
      gate_present = 1'b0;
      fire();
      expect_fault("R9 gate", 8'd11, 16'h0043);
      defaults();
      gate_present = 1'b0; gate_dpl = 2'd0;
      fire();
      expect_fault("R9 priority", 8'd13, 16'h0043);
      defaults();
      dest_present = 1'b0;
      fire();
      expect_fault("R9 dest", 8'd11, 16'h0028);
   endtask

   task automatic t_type_r13();
      defaults();
      gate_type = 4'h6;
      fire();
      expect_fault("R13", 8'd13, 16'h0043);
   endtask

   task automatic t_return_r10();
      defaults();
      req_op = 2'd3; cur_pl = 2'd0; ret_sel = 16'h004B; ret_off = 16'h0100;
      fire();
      chk("R10 out fault", 32'(fault), 32'd0);
      chk("R10 out cs", 32'(new_cs), 32'h004B);
      chk("R10 out ip", 32'(new_ip), 32'h0100);
      chk("R10 out cpl", 32'(new_cpl), 32'd3);
      chk("R10 out sw", 32'(stack_switch), 32'd1);
      chk("R10 out cnt", 32'(copy_words), 32'd0);
      req_op = 2'd3; cur_pl = 2'd3; ret_sel = 16'h0063; ret_off = 16'h0200;
      fire();
      chk("R10 same sw", 32'(stack_switch), 32'd0);
      chk("R10 same cs", 32'(new_cs), 32'h0063);
      chk("R10 same ip", 32'(new_ip), 32'h0200);
      req_op = 2'd3; cur_pl = 2'd3; ret_sel = 16'h0048; ret_off = 16'h0300;
      fire();
      expect_fault("R10 illegal", 8'd13, 16'h0048);
      chk("R11 ip held after return", 32'(new_ip), 32'h0200);
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      if (!done) begin
         fails++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      defaults();
      repeat (3) @(negedge clk);
      t_reset_r1();
      rst_n = 1'b1;
      @(negedge clk);
      t_inward_r6();
      t_inward_lvl1_r6();
      t_same_r7();
      t_gate_priv_r2();
      t_outward_r3();
      t_chain_r5();
      t_jump_r8();
      t_present_r9();
      t_type_r13();
      t_return_r10();
      @(negedge clk);
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule